// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block produces the two status indications a NOR-style flash controller shows to its host while an internal program or erase algorithm runs: the value returned on the top data bit (bit 7) when the host reads the bank being worked on, and an active-low ready/busy line. A command front end hands it one strobe per completed write cycle, tagged with the kind of sequence being entered. The internal algorithm engine reports completion. The host side supplies erase-suspend, resume and reset requests. A flag marks writes that target a protected sector.

A program needs four write cycles and an erase, chip-wide or per sector, needs six. The block counts these strobes itself. While a program runs, a read of the busy bank shows the inverse of bit 7 of the programmed data. While an erase runs, that bit reads 0. Reads of any other bank, and all reads once the block is idle, pass the array's own bit 7 through. Writes to a protected sector raise short, fixed-length busy windows and leave no trace. A reset that arrives while an algorithm is active holds the line busy for an internal reset interval. All window lengths are parameters counted in clock cycles.

The ready/busy output drives the enable of an open-drain pin: 1 pulls the line low (busy) and 0 releases it (ready). Both outputs are registered. Each reflects the state entered at the same clock edge that captures the causing input.

Top module: `flash_stat_gen`

## Requirements
- R1: During and right after synchronous reset, `rb_pull` is 0 and `dq7_out` is 0.
- R2: Four consecutive program strobes (`wr_kind` = 2'b01) start a program, and `rb_pull` is 1 from the edge that captures the fourth strobe. After only three strobes, `rb_pull` is still 0.
- R3: Six consecutive strobes of one erase kind (2'b10 chip, 2'b11 sector) start an erase and set `rb_pull` from the edge that captures the sixth. A strobe of another kind, including 2'b00, restarts the count.
- R4: While a program runs, a read with `rd_hit`=1 returns the inverse of `prog_d7` as captured with the fourth strobe. After `alg_done`, `rb_pull` is 0 and such reads return `arr_dq7`.
- R5: While an erase runs, a read with `rd_hit`=1 returns 0. After `alg_done`, `rb_pull` is 0 and reads return `arr_dq7`.
- R6: A read with `rd_hit`=0 always returns `arr_dq7`, one cycle later.
- R7: A program started with `prot_sect`=1 pulls `rb_pull` for exactly PROT_PROG_CYC cycles and reads the inverse data bit during that window. `alg_done` has no effect there, and the block then returns to idle.
- R8: An erase started with `prot_sect`=1 pulls `rb_pull` for exactly PROT_ERASE_CYC cycles and reads 0 during that window, then returns to idle.
- R9: While busy, complete program or erase sequences are ignored. After the running operation is done, the block is idle and `rb_pull` stays 0.
- R10: `susp_req` during an erase releases `rb_pull`, and a hit read returns 1. `resume_req` puts the erase back to busy, and a hit read returns 0.
- R11: While suspended, four program strobes start a program: `rb_pull` is 1 and hit reads return the inverse bit. Its `alg_done` returns the block to suspend. Erase sequences are ignored while suspended.
- R12: `reset_req` during an active or suspended algorithm keeps `rb_pull` at 1 for exactly RST_CYC cycles. `reset_req` while idle leaves `rb_pull` at 0.
- R13: If `alg_done` and `susp_req` arrive in the same cycle of an erase, completion wins and the block goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle strobe per completed write cycle |
| wr_kind | input | 2 | Sequence kind: 00 other, 01 program, 10 chip erase, 11 sector erase |
| prog_d7 | input | 1 | Bit 7 of the data being programmed |
| prot_sect | input | 1 | Target sector is protected |
| alg_done | input | 1 | Internal program/erase algorithm finished |
| susp_req | input | 1 | Erase-suspend command |
| resume_req | input | 1 | Erase-resume command |
| reset_req | input | 1 | Hardware reset request |
| rd_hit | input | 1 | Read targets the bank under operation |
| arr_dq7 | input | 1 | Bit 7 of the array data at the read address |
| dq7_out | output | 1 | Value returned on data bit 7 |
| rb_pull | output | 1 | 1 pulls ready/busy low (busy), 0 releases it |

## Verification
Two functions can collide in one cycle. An erase may complete on the very cycle the host asks for a suspend, and a complete command sequence may be strobed in while an algorithm is already busy. The bench drives `alg_done` and `susp_req` together during an erase and sets `arr_dq7` to 0. A hit read of 0 then tells idle apart from suspend, which would read 1. For the second collision, it drives full erase sequences into a running program and into a suspend. After completion it checks that the line stays released and that reads follow the array.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

  typedef enum logic [2:0] {
    ST_READY, ST_PROG, ST_ERASE, ST_ESUSP,
    ST_SPROG, ST_PPROT, ST_EPROT, ST_RSTW
  } fst_e;

  typedef enum logic [1:0] {
    WK_OTHER = 2'b00, WK_PROG = 2'b01, WK_CHIP = 2'b10, WK_SECT = 2'b11
  } wkind_e;

  typedef enum logic [1:0] {
    WIN_PPROT, WIN_EPROT, WIN_RST
  } win_e;

  function automatic logic alg_active(fst_e s);
    return s inside {ST_PROG, ST_ERASE, ST_ESUSP, ST_SPROG};
  endfunction

  function automatic logic holds_busy(fst_e s);
    return s inside {ST_PROG, ST_ERASE, ST_SPROG, ST_PPROT, ST_EPROT, ST_RSTW};
  endfunction

endpackage

// File: rtl/seq_counter.sv
module seq_counter
  import flash_stat_pkg::*;
#(
  parameter int PROG_WR  = 4,
  parameter int ERASE_WR = 6
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   stb,
  input  wkind_e kind,
  input  logic   allow_prog,
  input  logic   allow_erase,
  output logic   go_prog,
  output logic   go_erase
);
  localparam int MAXW = (PROG_WR > ERASE_WR) ? PROG_WR : ERASE_WR;
  localparam int CW   = $clog2(MAXW + 1);

  logic [CW-1:0] cnt;
  wkind_e        kind_q;
  logic          accept, same, fire;
  logic [CW-1:0] nxt, need;

  always_comb begin
    accept = stb && (kind != WK_OTHER) &&
             (((kind == WK_PROG) && allow_prog) ||
              ((kind != WK_PROG) && allow_erase));
    same   = (kind == kind_q) && (cnt != '0);
    nxt    = same ? cnt + 1'b1 : CW'(1);
    need   = (kind == WK_PROG) ? CW'(PROG_WR) : CW'(ERASE_WR);
    fire   = accept && (nxt == need);
  end

  assign go_prog  = fire && (kind == WK_PROG);
  assign go_erase = fire && (kind != WK_PROG);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      kind_q <= WK_OTHER;
    end else if (!allow_prog && !allow_erase) begin
      cnt    <= '0;
    end else if (stb) begin
      if (!accept || fire) begin
        cnt <= '0;
      end else begin
        cnt    <= nxt;
        kind_q <= kind;
      end
    end
  end

endmodule

// File: rtl/win_timer.sv
module win_timer
  import flash_stat_pkg::*;
#(
  parameter int PROT_PROG_CYC  = 8,
  parameter int PROT_ERASE_CYC = 40,
  parameter int RST_CYC        = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  win_e sel,
  output logic expire
);
  localparam int M1   = (PROT_PROG_CYC > PROT_ERASE_CYC) ? PROT_PROG_CYC : PROT_ERASE_CYC;
  localparam int MAXL = (M1 > RST_CYC) ? M1 : RST_CYC;
  localparam int TW   = $clog2(MAXL + 1);

  logic [TW-1:0] cnt, len;

  always_comb begin
    case (sel)
      WIN_PPROT: len = TW'(PROT_PROG_CYC);
      WIN_EPROT: len = TW'(PROT_ERASE_CYC);
      default:   len = TW'(RST_CYC);
    endcase
  end

  assign expire = (cnt == TW'(1));

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= len;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  // R7
  expire_after_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !expire);

endmodule

// File: rtl/status_fsm.sv
module status_fsm
  import flash_stat_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic go_prog,
  input  logic go_erase,
  input  logic prog_d7,
  input  logic prot_sect,
  input  logic alg_done,
  input  logic susp_req,
  input  logic resume_req,
  input  logic reset_req,
  input  logic win_exp,
  output fst_e state_q,
  output fst_e state_n,
  output logic d7_n,
  output logic tmr_load,
  output win_e tmr_sel,
  output logic allow_prog,
  output logic allow_erase
);
  logic d7_q;

  always_comb begin
    state_n = state_q;
    case (state_q)
      ST_READY: begin
        if (!reset_req) begin
          if (go_prog)       state_n = prot_sect ? ST_PPROT : ST_PROG;
          else if (go_erase) state_n = prot_sect ? ST_EPROT : ST_ERASE;
        end
      end
      ST_PROG: begin
        if (reset_req)     state_n = ST_RSTW;
        else if (alg_done) state_n = ST_READY;
      end
      ST_ERASE: begin
        if (reset_req)     state_n = ST_RSTW;
        else if (alg_done) state_n = ST_READY;
        else if (susp_req) state_n = ST_ESUSP;
      end
      ST_ESUSP: begin
        if (reset_req)                    state_n = ST_RSTW;
        else if (go_prog && !prot_sect)   state_n = ST_SPROG;
        else if (resume_req)              state_n = ST_ERASE;
      end
      ST_SPROG: begin
        if (reset_req)     state_n = ST_RSTW;
        else if (alg_done) state_n = ST_ESUSP;
      end
      ST_PPROT, ST_EPROT: begin
        if (reset_req || win_exp) state_n = ST_READY;
      end
      ST_RSTW: begin
        if (win_exp) state_n = ST_READY;
      end
      default: state_n = ST_READY;
    endcase
  end

  assign d7_n        = go_prog ? prog_d7 : d7_q;
  assign allow_prog  = (state_q == ST_READY) || (state_q == ST_ESUSP);
  assign allow_erase = (state_q == ST_READY);

  always_comb begin
    tmr_load = 1'b0;
    tmr_sel  = WIN_RST;
    if (state_n != state_q) begin
      case (state_n)
        ST_PPROT: begin tmr_load = 1'b1; tmr_sel = WIN_PPROT; end
        ST_EPROT: begin tmr_load = 1'b1; tmr_sel = WIN_EPROT; end
        ST_RSTW:  begin tmr_load = 1'b1; tmr_sel = WIN_RST;   end
        default:  tmr_load = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_READY;
      d7_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      d7_q    <= d7_n;
    end
  end

  // R10
  susp_release_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ERASE) && susp_req && !alg_done && !reset_req |=> state_q == ST_ESUSP);

  // R12
  rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    alg_active(state_q) && reset_req |=> state_q == ST_RSTW);

  // R13
  done_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ERASE) && alg_done && !reset_req |=> state_q == ST_READY);

endmodule

// File: rtl/flash_stat_gen.sv
module flash_stat_gen
  import flash_stat_pkg::*;
#(
  parameter int PROG_WR        = 4,
  parameter int ERASE_WR       = 6,
  parameter int PROT_PROG_CYC  = 8,
  parameter int PROT_ERASE_CYC = 40,
  parameter int RST_CYC        = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_stb,
  input  logic [1:0] wr_kind,
  input  logic       prog_d7,
  input  logic       prot_sect,
  input  logic       alg_done,
  input  logic       susp_req,
  input  logic       resume_req,
  input  logic       reset_req,
  input  logic       rd_hit,
  input  logic       arr_dq7,
  output logic       dq7_out,
  output logic       rb_pull
);
  logic go_prog, go_erase, allow_prog, allow_erase;
  logic tmr_load, win_exp, d7_n, hit_val;
  win_e tmr_sel;
  fst_e state_q, state_n;

  seq_counter #(.PROG_WR(PROG_WR), .ERASE_WR(ERASE_WR)) u_seq (
    .clk(clk), .rst(rst), .stb(wr_stb), .kind(wkind_e'(wr_kind)),
    .allow_prog(allow_prog), .allow_erase(allow_erase),
    .go_prog(go_prog), .go_erase(go_erase));

  win_timer #(.PROT_PROG_CYC(PROT_PROG_CYC), .PROT_ERASE_CYC(PROT_ERASE_CYC),
              .RST_CYC(RST_CYC)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .sel(tmr_sel), .expire(win_exp));

  status_fsm u_fsm (
    .clk(clk), .rst(rst), .go_prog(go_prog), .go_erase(go_erase),
    .prog_d7(prog_d7), .prot_sect(prot_sect), .alg_done(alg_done),
    .susp_req(susp_req), .resume_req(resume_req), .reset_req(reset_req),
    .win_exp(win_exp), .state_q(state_q), .state_n(state_n), .d7_n(d7_n),
    .tmr_load(tmr_load), .tmr_sel(tmr_sel),
    .allow_prog(allow_prog), .allow_erase(allow_erase));

  always_comb begin
    case (state_n)
      ST_PROG, ST_SPROG, ST_PPROT: hit_val = ~d7_n;
      ST_ERASE, ST_EPROT:          hit_val = 1'b0;
      ST_ESUSP:                    hit_val = 1'b1;
      default:                     hit_val = arr_dq7;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq7_out <= 1'b0;
      rb_pull <= 1'b0;
    end else begin
      dq7_out <= rd_hit ? hit_val : arr_dq7;
      rb_pull <= holds_busy(state_n);
    end
  end

  // R5
  erase_poll_low_chk: assert property (@(posedge clk) disable iff (rst)
    (state_n == ST_ERASE) && rd_hit |=> !dq7_out);

  // R6
  miss_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> dq7_out == $past(arr_dq7));

  // R9
  rb_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rb_pull) |-> $past(wr_stb || resume_req || reset_req));

endmodule

// File: tb/sim_flash_stat_gen.sv
`timescale 1ns/1ps
module sim_flash_stat_gen;
  localparam int PP = 8, EP = 40, RC = 12;

  logic clk = 0, rst = 1;
  logic wr_stb = 0, prog_d7 = 0, prot_sect = 0, alg_done = 0;
  logic susp_req = 0, resume_req = 0, reset_req = 0, rd_hit = 0, arr_dq7 = 0;
  logic [1:0] wr_kind = 2'b00;
  logic dq7_out, rb_pull;
  int checks = 0, errors = 0;
  logic cur_d7 = 0;

  always #4 clk = ~clk;

  flash_stat_gen #(.PROT_PROG_CYC(PP), .PROT_ERASE_CYC(EP), .RST_CYC(RC)) u0 (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_kind(wr_kind), .prog_d7(prog_d7),
    .prot_sect(prot_sect), .alg_done(alg_done), .susp_req(susp_req),
    .resume_req(resume_req), .reset_req(reset_req), .rd_hit(rd_hit),
    .arr_dq7(arr_dq7), .dq7_out(dq7_out), .rb_pull(rb_pull));

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got=%0b expected=%0b", tag, got, exp);
    end
  endtask

  task automatic strobe(input logic [1:0] k, input logic d);
    wr_stb = 1; wr_kind = k; prog_d7 = d;
    step();
    wr_stb = 0; wr_kind = 2'b00;
  endtask

  task automatic seq(input logic [1:0] k, input int n, input logic d);
    for (int i = 0; i < n; i++) strobe(k, d);
  endtask

  task automatic pulse_done();
    alg_done = 1; step(); alg_done = 0;
  endtask

  // expected hit-read value in a given mode: 0 idle, 1 program, 2 erase, 3 suspend
  function automatic logic exp_read(int mode, logic hit, logic arr, logic d7);
    if (!hit) return arr;
    case (mode)
      1: return ~d7;
      2: return 1'b0;
      3: return 1'b1;
      default: return arr;
    endcase
  endfunction

  task automatic rand_reads(input int mode, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic h, a;
      h = 1'($urandom_range(1)); a = 1'($urandom_range(1));
      rd_hit = h; arr_dq7 = a;
      step();
      chk(dq7_out, exp_read(mode, h, a, cur_d7), tag);
    end
  endtask

  task automatic read_chk(input logic h, input logic a, input logic exp, input string tag);
    rd_hit = h; arr_dq7 = a; step(); chk(dq7_out, exp, tag);
  endtask

  task automatic count_busy(input int lim, output int n);
    n = 0;
    while (rb_pull === 1'b1 && n < lim) begin n++; step(); end
  endtask

  initial begin
    int n;
    void'($urandom(32'd4242));
    repeat (3) step();
    chk(rb_pull, 1'b0, "R1 rb in reset");
    chk(dq7_out, 1'b0, "R1 dq7 in reset");
    rst = 0;
    step();
    chk(rb_pull, 1'b0, "R1 rb after reset");

    read_chk(0, 1, 1, "R6 miss read");
    read_chk(0, 0, 0, "R6 miss read");

    // R2 / R4 program
    seq(2'b01, 3, 1);
    chk(rb_pull, 1'b0, "R2 three strobes idle");
    cur_d7 = 1; strobe(2'b01, 1);
    chk(rb_pull, 1'b1, "R2 fourth strobe busy");
    rand_reads(1, 20, "R4 program poll");
    // R9 complete erase sequence while busy
    seq(2'b10, 6, 0);
    chk(rb_pull, 1'b1, "R9 still busy");
    rd_hit = 1; arr_dq7 = 1; pulse_done();
    chk(rb_pull, 1'b0, "R4 released after done");
    chk(dq7_out, 1'b1, "R4 true data after done");
    step();
    chk(rb_pull, 1'b0, "R9 ignored erase not started");
    rand_reads(0, 8, "R4 idle reads");

    // R3 restart on kind change
    seq(2'b11, 5, 0); strobe(2'b10, 0);
    chk(rb_pull, 1'b0, "R3 kind change restarts");
    seq(2'b10, 4, 0); strobe(2'b00, 0); seq(2'b10, 2, 0);
    chk(rb_pull, 1'b0, "R3 other kind restarts");
    seq(2'b10, 6, 0);
    chk(rb_pull, 1'b1, "R3 chip erase busy");
    rand_reads(2, 20, "R5 erase poll");
    rd_hit = 1; arr_dq7 = 1; pulse_done();
    chk(rb_pull, 1'b0, "R5 released");
    chk(dq7_out, 1'b1, "R5 array after done");

    // R13 done and suspend together
    seq(2'b11, 6, 0);
    chk(rb_pull, 1'b1, "R3 sector erase busy");
    rd_hit = 1; arr_dq7 = 0; alg_done = 1; susp_req = 1; step();
    alg_done = 0; susp_req = 0;
    chk(rb_pull, 1'b0, "R13 done wins rb");
    chk(dq7_out, 1'b0, "R13 done wins read");

    // R10 / R11 suspend
    seq(2'b11, 6, 0);
    susp_req = 1; rd_hit = 1; arr_dq7 = 0; step(); susp_req = 0;
    chk(rb_pull, 1'b0, "R10 suspend releases");
    chk(dq7_out, 1'b1, "R10 suspend read");
    seq(2'b10, 6, 0);
    chk(rb_pull, 1'b0, "R11 erase ignored in suspend");
    read_chk(1, 0, 1, "R11 still suspended");
    cur_d7 = 0; seq(2'b01, 4, 0);
    chk(rb_pull, 1'b1, "R11 suspend program busy");
    rand_reads(1, 10, "R11 suspend program poll");
    rd_hit = 1; arr_dq7 = 0; pulse_done();
    chk(rb_pull, 1'b0, "R11 back to suspend");
    chk(dq7_out, 1'b1, "R11 suspend read again");
    resume_req = 1; step(); resume_req = 0;
    chk(rb_pull, 1'b1, "R10 resume busy");
    chk(dq7_out, 1'b0, "R10 resume read");
    pulse_done();
    chk(rb_pull, 1'b0, "R5 done after resume");

    // R7 protected program
    prot_sect = 1; cur_d7 = 0;
    rd_hit = 1; arr_dq7 = 0;
    seq(2'b01, 4, 0);
    chk(dq7_out, 1'b1, "R7 prot poll inverse");
    alg_done = 1;
    count_busy(1000, n);
    alg_done = 0;
    checks++;
    if (n != PP) begin errors++; $display("FAIL R7: busy=%0d expected=%0d", n, PP); end
    prot_sect = 0;
    read_chk(1, 1, 1, "R7 idle after window");

    // R8 protected erase
    prot_sect = 1;
    seq(2'b11, 6, 0);
    chk(dq7_out, 1'b0, "R8 prot erase poll");
    count_busy(1000, n);
    checks++;
    if (n != EP) begin errors++; $display("FAIL R8: busy=%0d expected=%0d", n, EP); end
    prot_sect = 0;

    // R12 reset during program
    cur_d7 = 1; seq(2'b01, 4, 1);
    reset_req = 1; step(); reset_req = 0;
    count_busy(1000, n);
    checks++;
    if (n != RC) begin errors++; $display("FAIL R12: busy=%0d expected=%0d", n, RC); end
    reset_req = 1; step(); reset_req = 0;
    chk(rb_pull, 1'b0, "R12 idle reset no busy");
    rand_reads(0, 10, "R6 idle random reads");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule